// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block takes one operation request at a time from a host and plays out, on an asynchronous 16-bit parallel NOR flash bus, the series of bus writes that the flash's command state machine expects for that operation. The host presents an operation code, a target word address and a data word with a one-cycle valid. The block then produces every write itself: address, data and the active-low chip-enable and write-enable strobes. When the last write has completed it signals done.

Six operations are encoded: identifier entry, return to array read, single-word program, sector erase, full-chip erase and query-mode entry. The multi-write operations start with the two-write unlock handshake. The two erase operations repeat that handshake after an erase-setup write. Every command offset is a word offset inside the flash. The block adds it, scaled by two for the byte-addressed bus, to a fixed bank base. A lock input stops the three operations that change array contents. A request that arrives while a sequence is running is turned away with a one-cycle pulse and is not stored.

Top module: `nor_cmd_seq`

## Requirements
- R1: The unlock handshake is data 0xAA to word offset 0x555, then data 0x55 to word offset 0x2AA, in that order. It opens identifier entry, program, and both erases, and it appears a second time as writes 4 and 5 of each erase.
- R2: Op code 0 (identifier entry) makes three writes: the handshake, then 0x90 to offset 0x555.
- R3: Op code 2 (program) makes four writes: the handshake, then 0xA0 to offset 0x555, then the request data word to the request word address.
- R4: Op code 3 (sector erase) makes six writes: the handshake, then 0x80 to 0x555, the handshake again, then 0x30 to the request word address.
- R5: Op code 4 (chip erase) makes the same writes as op code 3, except that the sixth write is 0x10 to offset 0x555.
- R6: Op code 1 (return to read) makes one write, 0xF0 to word offset 0. Op code 5 (query entry) makes one write, 0x98 to word offset 0x55.
- R7: Every bus byte address equals BANK_BASE plus twice the word offset.
- R8: Each write holds bus_ce_n and bus_we_n low together for exactly STROBE_CYC cycles, with address and data unchanged during that time. One cycle with both strobes high follows each write.
- R9: A request is accepted when req_valid is high on an edge at which busy is low. busy is high from the next cycle until the final idle cycle. done then pulses for exactly one cycle, with busy low.
- R10: A request that arrives while busy is high gives a one-cycle pulse on rejected in the next cycle. It leaves the running sequence unchanged and is never carried out.
- R11: While lock_i is high, op codes 2, 3 and 4 make no bus write, leave busy low and give a one-cycle pulse on refused. Op codes 0, 1 and 5 still run.
- R12: Op codes 6 and 7 are ignored: no bus write, no busy, no done, no rejected, no refused.
- R13: After reset, busy, done, rejected and refused are low, and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 3 | Operation code (0 to 5 defined) |
| req_addr | input | ADDR_W | Target word address for program and sector erase |
| req_data | input | DATA_W | Data word for program |
| lock_i | input | 1 | High blocks program and erase |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |
| rejected | output | 1 | One-cycle pulse: request arrived while busy |
| refused | output | 1 | One-cycle pulse: modifying request blocked by lock |
| bus_addr | output | BUS_AW | Flash byte address |
| bus_data | output | DATA_W | Flash write data |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_we_n | output | 1 | Write enable, active low |

## Verification
A wrong step counter or sequence table entry shows up as a wrong address or data word on the bus during the strobe of the affected write. The write count and the cycle on which done appears then also differ from the expected n·(STROBE_CYC+1)+1 cycles after acceptance. A wrong strobe counter changes the low width of bus_we_n on the very first write. Faults in acceptance or locking appear one cycle after the request: as a missing or stray pulse on rejected or refused, or as busy rising when it should not.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam int STEP_W = 3;
  localparam int OFS_W  = 11;

  typedef enum logic [2:0] {
    OP_ID     = 3'd0,
    OP_RDMODE = 3'd1,
    OP_PROG   = 3'd2,
    OP_SECT   = 3'd3,
    OP_CHIP   = 3'd4,
    OP_QUERY  = 3'd5
  } nor_op_e;

  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_STROBE = 2'd1,
    ENG_GAP    = 2'd2
  } eng_state_e;

  // word offsets decoded by the flash command state machine
  localparam logic [OFS_W-1:0] OFS_KEY_A = 11'h555;
  localparam logic [OFS_W-1:0] OFS_KEY_B = 11'h2AA;
  localparam logic [OFS_W-1:0] OFS_QUERY = 11'h055;
  localparam logic [OFS_W-1:0] OFS_HOME  = 11'h000;

  localparam logic [7:0] DAT_KEY_A  = 8'hAA;
  localparam logic [7:0] DAT_KEY_B  = 8'h55;
  localparam logic [7:0] DAT_ID     = 8'h90;
  localparam logic [7:0] DAT_PROG   = 8'hA0;
  localparam logic [7:0] DAT_ESETUP = 8'h80;
  localparam logic [7:0] DAT_SECT   = 8'h30;
  localparam logic [7:0] DAT_CHIP   = 8'h10;
  localparam logic [7:0] DAT_RDMODE = 8'hF0;
  localparam logic [7:0] DAT_QUERY  = 8'h98;

  function automatic logic op_known(input logic [2:0] op);
    return op <= 3'd5;
  endfunction

  function automatic logic op_modifies(input logic [2:0] op);
    return (op == OP_PROG) || (op == OP_SECT) || (op == OP_CHIP);
  endfunction

endpackage

// File: rtl/nor_seq_table.sv
module nor_seq_table
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic [2:0]        op,
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] tgt_word,
  input  logic [DATA_W-1:0] usr_data,
  output logic [ADDR_W-1:0] word_ofs,
  output logic [DATA_W-1:0] wr_data,
  output logic              last
);

  logic             use_tgt;
  logic             use_usr;
  logic [OFS_W-1:0] ofs;
  logic [7:0]       cmd;
  logic             key_b_step;

  // steps 1 and 4 carry the second handshake key
  assign key_b_step = (step == 3'd1) || (step == 3'd4);

  always_comb begin
    use_tgt = 1'b0;
    use_usr = 1'b0;
    ofs     = OFS_HOME;
    cmd     = 8'h00;
    last    = 1'b0;
    case (op)
      OP_RDMODE: begin
        ofs  = OFS_HOME;
        cmd  = DAT_RDMODE;
        last = 1'b1;
      end
      OP_QUERY: begin
        ofs  = OFS_QUERY;
        cmd  = DAT_QUERY;
        last = 1'b1;
      end
      OP_ID: begin
        if (step < 3'd2) begin
          ofs = key_b_step ? OFS_KEY_B : OFS_KEY_A;
          cmd = key_b_step ? DAT_KEY_B : DAT_KEY_A;
        end else begin
          ofs  = OFS_KEY_A;
          cmd  = DAT_ID;
          last = 1'b1;
        end
      end
      OP_PROG: begin
        if (step < 3'd2) begin
          ofs = key_b_step ? OFS_KEY_B : OFS_KEY_A;
          cmd = key_b_step ? DAT_KEY_B : DAT_KEY_A;
        end else if (step == 3'd2) begin
          ofs = OFS_KEY_A;
          cmd = DAT_PROG;
        end else begin
          use_tgt = 1'b1;
          use_usr = 1'b1;
          last    = 1'b1;
        end
      end
      OP_SECT, OP_CHIP: begin
        if (step == 3'd2) begin
          ofs = OFS_KEY_A;
          cmd = DAT_ESETUP;
        end else if (step < 3'd5) begin
          ofs = key_b_step ? OFS_KEY_B : OFS_KEY_A;
          cmd = key_b_step ? DAT_KEY_B : DAT_KEY_A;
        end else begin
          last = 1'b1;
          if (op == OP_SECT) begin
            use_tgt = 1'b1;
            cmd     = DAT_SECT;
          end else begin
            ofs = OFS_KEY_A;
            cmd = DAT_CHIP;
          end
        end
      end
      default: begin
        last = 1'b1;
      end
    endcase
  end

  assign word_ofs = use_tgt ? tgt_word : {{(ADDR_W-OFS_W){1'b0}}, ofs};
  assign wr_data  = use_usr ? usr_data : {{(DATA_W-8){1'b0}}, cmd};

endmodule

// File: rtl/nor_step_engine.sv
module nor_step_engine
  import nor_seq_pkg::*;
#(
  parameter int STROBE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              last,
  output logic              busy,
  output logic              strobe,
  output logic [STEP_W-1:0] step,
  output logic              done
);

  localparam int CNT_W = $clog2(STROBE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STROBE_CYC - 1);

  eng_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    step_d  = step_q;
    done_d  = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (start) begin
          state_d = ENG_STROBE;
          cnt_d   = '0;
          step_d  = '0;
        end
      end
      ENG_STROBE: begin
        if (cnt_q == CNT_END) begin
          state_d = ENG_GAP;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ENG_GAP: begin
        if (last) begin
          state_d = ENG_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ENG_STROBE;
          cnt_d   = '0;
          step_d  = step_q + STEP_W'(1);
        end
      end
      default: begin
        state_d = ENG_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      step_q  <= step_d;
      done_q  <= done_d;
    end
  end

  assign busy   = (state_q != ENG_IDLE);
  assign strobe = (state_q == ENG_STROBE);
  assign step   = step_q;
  assign done   = done_q;

endmodule

// File: rtl/nor_addr_map.sv
module nor_addr_map #(
  parameter int                ADDR_W    = 22,
  parameter int                BUS_AW    = 26,
  parameter logic [BUS_AW-1:0] BANK_BASE = '0
) (
  input  logic [ADDR_W-1:0] word_ofs,
  output logic [BUS_AW-1:0] byte_addr
);

  localparam int PAD_W = BUS_AW - ADDR_W - 1;

  // 16-bit device on a byte-addressed bus: word offset scaled by two
  assign byte_addr = BANK_BASE + {{PAD_W{1'b0}}, word_ofs, 1'b0};

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int                ADDR_W     = 22,
  parameter int                DATA_W     = 16,
  parameter int                BUS_AW     = 26,
  parameter logic [BUS_AW-1:0] BANK_BASE  = 26'h100_0000,
  parameter int                STROBE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              lock_i,
  output logic              busy,
  output logic              done,
  output logic              rejected,
  output logic              refused,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_ce_n,
  output logic              bus_we_n
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              eng_busy;
  logic              eng_strobe;
  logic              eng_done;
  logic              tbl_last;
  logic [STEP_W-1:0] eng_step;
  logic [ADDR_W-1:0] tbl_word;
  logic [DATA_W-1:0] tbl_data;

  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              rej_q, rej_d;
  logic              ref_q, ref_d;
  logic              accept;
  logic              blocked;

  assign blocked = lock_i && op_modifies(req_op);
  assign accept  = req_valid && !eng_busy && op_known(req_op) && !blocked;

  always_comb begin
    rej_d = req_valid && eng_busy;
    ref_d = req_valid && !eng_busy && op_known(req_op) && blocked;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rej_q <= 1'b0;
      ref_q <= 1'b0;
    end else begin
      rej_q <= rej_d;
      ref_q <= ref_d;
    end
  end

  // request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q   <= OP_RDMODE;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      op_q   <= req_op;
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  nor_step_engine #(
    .STROBE_CYC(STROBE_CYC)
  ) engine_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (accept),
    .last  (tbl_last),
    .busy  (eng_busy),
    .strobe(eng_strobe),
    .step  (eng_step),
    .done  (eng_done)
  );

  nor_seq_table #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) table_i (
    .op      (op_q),
    .step    (eng_step),
    .tgt_word(addr_q),
    .usr_data(data_q),
    .word_ofs(tbl_word),
    .wr_data (tbl_data),
    .last    (tbl_last)
  );

  nor_addr_map #(
    .ADDR_W   (ADDR_W),
    .BUS_AW   (BUS_AW),
    .BANK_BASE(BANK_BASE)
  ) map_i (
    .word_ofs (tbl_word),
    .byte_addr(bus_addr)
  );

  assign bus_data = tbl_data;
  assign bus_ce_n = !eng_strobe;
  assign bus_we_n = !eng_strobe;
  assign busy     = eng_busy;
  assign done     = eng_done;
  assign rejected = rej_q;
  assign refused  = ref_q;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int BUS_AW     = 26,
  parameter int DATA_W     = 16,
  parameter int STROBE_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              lock_i,
  input logic              busy,
  input logic              done,
  input logic              rejected,
  input logic              refused,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_ce_n,
  input logic              bus_we_n
);

  localparam int LW = $clog2(STROBE_CYC + 2);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_cnt <= '0;
    else if (!bus_we_n) low_cnt <= low_cnt + LW'(1);
    else                low_cnt <= '0;
  end

  // R8: strobe width measured when write enable returns high
  a_r8_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_n && low_cnt != '0) |-> (low_cnt == LW'(STROBE_CYC)));

  // R8: address and data held through a strobe
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we_n && $past(!bus_we_n)) |-> ($stable(bus_addr) && $stable(bus_data)));

  // R8: chip enable and write enable move together
  a_r8_ce_with_we: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ce_n == bus_we_n);

  // R9: no strobe outside a running sequence
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_we_n);

  // R9: done comes with busy low, right after a busy cycle
  a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: a reject only follows a request seen while busy
  a_r10_reject_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> ($past(busy) && $past(req_valid)));

  // R11: a refusal follows a locked request and starts nothing
  a_r11_refuse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    refused |-> (!busy && $past(lock_i) && $past(req_valid)));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(
  .BUS_AW    (BUS_AW),
  .DATA_W    (DATA_W),
  .STROBE_CYC(STROBE_CYC)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .lock_i   (lock_i),
  .busy     (busy),
  .done     (done),
  .rejected (rejected),
  .refused  (refused),
  .bus_addr (bus_addr),
  .bus_data (bus_data),
  .bus_ce_n (bus_ce_n),
  .bus_we_n (bus_we_n)
);

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;

  localparam int          ADDR_W = 22;
  localparam int          DATA_W = 16;
  localparam int          BUS_AW = 26;
  localparam logic [25:0] BASE   = 26'h100_0000;
  localparam int          S      = 3;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [2:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  logic              lock_i;
  logic              busy, done, rejected, refused;
  logic [BUS_AW-1:0] bus_addr;
  logic [DATA_W-1:0] bus_data;
  logic              bus_ce_n, bus_we_n;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  nor_cmd_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_AW(BUS_AW),
    .BANK_BASE(BASE), .STROBE_CYC(S)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .lock_i(lock_i),
    .busy(busy), .done(done), .rejected(rejected), .refused(refused),
    .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [2:0] op);
    case (op)
      3'd0: return 3;
      3'd1: return 1;
      3'd2: return 4;
      3'd3, 3'd4: return 6;
      3'd5: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] exp_word(input logic [2:0] op, input int i,
                                                 input logic [ADDR_W-1:0] tgt);
    if (op == 3'd1) return '0;
    if (op == 3'd5) return 22'h55;
    if (op == 3'd2 && i == 3) return tgt;
    if (i == 5) return (op == 3'd3) ? tgt : 22'h555;
    if (i == 1 || i == 4) return 22'h2AA;
    return 22'h555;
  endfunction

  function automatic logic [DATA_W-1:0] exp_dat(input logic [2:0] op, input int i,
                                                input logic [DATA_W-1:0] d);
    if (op == 3'd1) return 16'hF0;
    if (op == 3'd5) return 16'h98;
    if (i == 0 || (i == 3 && op != 3'd2)) return 16'hAA;
    if (i == 1 || i == 4) return 16'h55;
    if (i == 2) return (op == 3'd0) ? 16'h90 : (op == 3'd2) ? 16'hA0 : 16'h80;
    if (op == 3'd2) return d;
    return (op == 3'd3) ? 16'h30 : 16'h10;
  endfunction

  function automatic string op_tag(input logic [2:0] op, input int i);
    if (op == 3'd1 || op == 3'd5) return "R6";
    if (i < 2 || ((op == 3'd3 || op == 3'd4) && (i == 3 || i == 4))) return "R1";
    case (op)
      3'd0: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [ADDR_W-1:0] tgt,
                        input logic [DATA_W-1:0] d, input bit lk, input bit intrude);
    bit acc;
    bit modif;
    int n;
    int span;
    int idx;
    int lowlen;
    bit prev_we;
    bit busy_ok;
    logic [BUS_AW-1:0] hold_a;
    logic [DATA_W-1:0] hold_d;
    modif  = (op == 3'd2) || (op == 3'd3) || (op == 3'd4);
    acc    = (op <= 3'd5) && !(lk && modif);
    n      = acc ? exp_len(op) : 0;
    span   = acc ? n * (S + 1) + 1 : 8;
    idx    = -1;
    lowlen = 0;
    prev_we = 1'b1;
    busy_ok = 1'b1;
    hold_a = '0;
    hold_d = '0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = tgt; req_data = d; lock_i = lk;
    for (int cyc = 1; cyc <= span; cyc++) begin
      @(negedge clk);
      if (cyc == 1) begin
        req_valid = 1'b0;
        if (!acc) begin
          chk(busy == 1'b0, (op > 3'd5) ? "R12" : "R11", "busy after blocked request", busy, 0);
          chk(refused == (op <= 3'd5 && lk && modif), (op > 3'd5) ? "R12" : "R11",
              "refused pulse", refused, (op <= 3'd5 && lk && modif));
        end else begin
          chk(refused == 1'b0, "R11", "refused on allowed op", refused, 0);
        end
      end
      chk(bus_ce_n == bus_we_n, "R8", "ce/we pairing", bus_ce_n, bus_we_n);
      if (!bus_we_n) begin
        if (prev_we) begin
          idx++;
          lowlen = 1;
          hold_a = bus_addr;
          hold_d = bus_data;
          if (idx < n) begin
            chk(bus_addr == BASE + {3'b000, exp_word(op, idx, tgt), 1'b0}, "R7",
                $sformatf("addr op%0d write%0d", op, idx), bus_addr,
                BASE + {3'b000, exp_word(op, idx, tgt), 1'b0});
            chk(bus_data == exp_dat(op, idx, d), op_tag(op, idx),
                $sformatf("data op%0d write%0d", op, idx), bus_data, exp_dat(op, idx, d));
          end
        end else begin
          lowlen++;
          if (bus_addr != hold_a || bus_data != hold_d)
            chk(1'b0, "R8", "addr/data moved in strobe", bus_addr, hold_a);
        end
      end else if (!prev_we) begin
        chk(lowlen == S, "R8", "strobe width", lowlen, S);
      end
      prev_we = bus_we_n;
      if (acc && cyc <= n * (S + 1) && !busy) busy_ok = 1'b0;
      if (!acc && busy) busy_ok = 1'b0;
      if (intrude && acc && cyc == 2) begin
        req_valid = 1'b1; req_op = 3'd2; req_addr = ~tgt; req_data = ~d;
      end
      if (intrude && acc && cyc == 3) begin
        chk(rejected == 1'b1, "R10", "rejected pulse", rejected, 1);
        req_valid = 1'b0;
      end
      if (acc && cyc < span && done) chk(1'b0, "R9", "early done", cyc, span);
    end
    chk(busy_ok, acc ? "R9" : "R12", "busy span", busy_ok, 1);
    chk(idx + 1 == n, acc ? "R10" : ((op > 3'd5) ? "R12" : "R11"), "write count", idx + 1, n);
    if (acc) begin
      chk(done == 1'b1 && busy == 1'b0, "R9", "done with busy low", {done, busy}, 2'b10);
      @(negedge clk);
      chk(done == 1'b0, "R9", "done single pulse", done, 0);
    end else begin
      chk(done == 1'b0 && rejected == 1'b0, "R12", "no done/reject", {done, rejected}, 0);
    end
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0; lock_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(busy == 0 && done == 0 && rejected == 0 && refused == 0, "R13", "flags after reset",
        {busy, done, rejected, refused}, 0);
    chk(bus_ce_n == 1 && bus_we_n == 1, "R13", "strobes after reset", {bus_ce_n, bus_we_n}, 2'b11);
    // directed: every op once, unlocked
    for (int o = 0; o < 6; o++) run_op(3'(o), 22'h12345, 16'hBEEF, 1'b0, 1'b0);
    // R7 extreme target addresses
    run_op(3'd2, 22'h3FFFFF, 16'hFFFF, 1'b0, 1'b0);
    run_op(3'd3, 22'h000000, 16'h0000, 1'b0, 1'b0);
    // R10 intrusion on shortest and longest sequences
    run_op(3'd1, 22'h0, 16'h0, 1'b0, 1'b1);
    run_op(3'd4, 22'h0, 16'h0, 1'b0, 1'b1);
    // R11 lock: modifying refused, others still run
    run_op(3'd2, 22'h00abc, 16'h1234, 1'b1, 1'b0);
    run_op(3'd3, 22'h00abc, 16'h1234, 1'b1, 1'b0);
    run_op(3'd4, 22'h00abc, 16'h1234, 1'b1, 1'b0);
    run_op(3'd0, 22'h00abc, 16'h1234, 1'b1, 1'b0);
    run_op(3'd5, 22'h00abc, 16'h1234, 1'b1, 1'b0);
    // R12 undefined codes
    run_op(3'd6, 22'h1, 16'h1, 1'b0, 1'b0);
    run_op(3'd7, 22'h1, 16'h1, 1'b0, 1'b0);
    // random mix
    for (int k = 0; k < 60; k++) begin
      run_op(3'($urandom_range(0, 7)), 22'($urandom), 16'($urandom),
             ($urandom_range(0, 3) == 0), $urandom_range(0, 1) == 1);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule